// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds received packets for a single USB OUT endpoint. Bytes arrive on the bus side one per write strobe. A one-cycle end-of-packet pulse then marks the packet as good or bad. A good packet that fits in a slot and finds a free slot is committed. Anything else is thrown away. On the CPU side, software reads a two-bit status code and the byte count of the oldest packet. It then pops that packet's bytes one at a time. The packet is released either by a clear-ready strobe or automatically once its last byte has been popped.

A mode input selects how many slots are used. In single mode one slot is used. In double mode two slots are used in alternation, so the bus can fill one slot while the CPU drains the other. A good packet that arrives with no free slot is lost, and a sticky overrun flag records the loss. The mode is expected to change only while the buffer is empty.

Top module: `usb_out_ep_buffer`

## Requirements
- R1: After reset, the status is 00, the head count is 0, the overrun flag is 0 and the pop data is 0x00.
- R2: Status 00 means no packet is held, and status code 01 is never produced.
- R3: In single mode (`dbl_mode`=0), one held packet gives status 11, status 10 never appears, and a second good packet while one is held is an overrun.
- R4: In double mode (`dbl_mode`=1), one held packet gives status 10 and two held packets give status 11.
- R5: `head_len` equals the byte count of the oldest held packet, and is 0 when no packet is held.
- R6: Each `pop` pulse yields the next byte of the oldest packet, in write order, on `pop_data` in the cycle after the pulse.
- R7: A `clr_rdy` pulse releases the oldest packet and updates the status. When the status is 00, the pulse is ignored.
- R8: With `auto_clr` high, the oldest packet is released in the same cycle its last counted byte is popped, with no `clr_rdy` needed.
- R9: A good packet finding no free slot is dropped and sets `overrun`, and the held packets are not changed. A pulse on `overrun_clr` clears the flag. A new drop in the same cycle takes precedence.
- R10: A packet ended with `eop_good`=0 is discarded and never counted as held.
- R11: A packet longer than `SLOT_BYTES` is discarded. A packet of exactly `SLOT_BYTES` is accepted.
- R12: A pop when no packet is held, or past the end of the head packet, returns 0x00 and changes nothing else.
- R13: In double mode, packets are presented in arrival order with the slots reused in ping-pong order, and `head_len` follows the head packet as packets are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbl_mode | input | 1 | 1 = two slots in ping-pong, 0 = one slot |
| auto_clr | input | 1 | Release the head packet automatically after its last byte is popped |
| wr_en | input | 1 | Bus-side byte write strobe |
| wr_byte | input | 8 | Bus-side byte |
| eop | input | 1 | End-of-packet pulse |
| eop_good | input | 1 | Qualifies `eop`: 1 = keep the packet, 0 = discard it |
| status | output | 2 | Buffer status code |
| head_len | output | $clog2(SLOT_BYTES+1) | Byte count of the oldest held packet |
| pop | input | 1 | CPU pop strobe |
| pop_data | output | 8 | Popped byte, registered |
| clr_rdy | input | 1 | Release the oldest packet |
| overrun | output | 1 | Sticky dropped-packet flag |
| overrun_clr | input | 1 | Clears `overrun` |

## Verification
The bench builds the block with `SLOT_BYTES`=8. With this value, both the exact-fit packet and the one-byte-too-long packet take only a few cycles. It also lets a full double-mode slot cycle, including slot reuse, run many times in a short test. Byte values come from a per-packet base value, so a byte delivered out of order or from the wrong slot shows up as a value mismatch, not a silent pass.

// File: rtl/oep_pkg.sv
// Shared types for the OUT endpoint receive buffer.
// Assumes a held-packet count of at most two.
package oep_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'b00,
        ST_UNUSED  = 2'b01,
        ST_HALF    = 2'b10,
        ST_FULL    = 2'b11
    } oep_stat_e;

    // Maps mode and held-packet count onto the CPU status code.
    function automatic oep_stat_e enc_status(input logic dbl, input logic [1:0] held);
        oep_stat_e s;
        if (held == 2'd0)
            s = ST_EMPTY;
        else if (!dbl)
            s = ST_FULL;
        else if (held == 2'd1)
            s = ST_HALF;
        else
            s = ST_FULL;
        return s;
    endfunction

endpackage

// File: rtl/oep_slot_ram.sv
// Two-slot byte storage for the receive buffer.
// One write port (bus side) and one registered read port (CPU side).
// Assumes the writer never targets the slot that the reader is draining.
module oep_slot_ram #(
    parameter int SLOT_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wr_slot,
    input  logic [CNT_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic              rd_slot,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH  = 2 * SLOT_BYTES;
    localparam int ADDR_W = CNT_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    // Flat addresses: the slot picks the half, the index the byte within it.
    always_comb begin
        wr_addr = ADDR_W'(wr_slot) * ADDR_W'(SLOT_BYTES) + {1'b0, wr_idx};
        rd_addr = ADDR_W'(rd_slot) * ADDR_W'(SLOT_BYTES) + {1'b0, rd_idx};
    end

    // Stores a bus-side byte.
    always_ff @(posedge clk) begin
        if (we)
            mem[wr_addr] <= wr_data;
    end

    // Registers the popped byte, giving zero for a pop with nothing to return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_hit ? mem[rd_addr] : '0;
    end

endmodule

// File: rtl/oep_fill_ctrl.sv
// Bus-side packet assembler.
// Counts the bytes of the packet being received and writes them into the
// free slot the queue names. At end of packet it decides whether to commit,
// silently discard (bad or too long) or drop with overrun (no room).
// Assumes eop may coincide with the last byte's wr_en.
module oep_fill_ctrl #(
    parameter int SLOT_BYTES = 64,
    parameter int CNT_W      = $clog2(SLOT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             eop,
    input  logic             eop_good,
    input  logic             room_now,
    output logic             mem_we,
    output logic [CNT_W-1:0] fill_idx,
    output logic             commit,
    output logic [CNT_W-1:0] commit_len,
    output logic             drop
);
    localparam logic [CNT_W-1:0] SLOT_LIM = CNT_W'(SLOT_BYTES);

    logic fill_active_q;
    logic room_q;
    logic long_q;
    logic [CNT_W-1:0] fill_cnt_q;

    logic byte_fits;
    logic room_eff;
    logic long_now;

    // Room is locked at the first byte so a packet is never split across states.
    always_comb begin
        byte_fits  = fill_cnt_q < SLOT_LIM;
        room_eff   = fill_active_q ? room_q : room_now;
        long_now   = long_q || (wr_en && !byte_fits);
        mem_we     = wr_en && byte_fits && room_eff;
        fill_idx   = fill_cnt_q;
        commit_len = fill_cnt_q + CNT_W'(wr_en && byte_fits);
        commit     = eop && eop_good && !long_now && room_eff;
        drop       = eop && eop_good && !long_now && !room_eff;
    end

    // Tracks count, room lock and length overflow for the packet in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_active_q <= 1'b0;
            room_q        <= 1'b0;
            long_q        <= 1'b0;
            fill_cnt_q    <= '0;
        end else if (eop) begin
            fill_active_q <= 1'b0;
            room_q        <= 1'b0;
            long_q        <= 1'b0;
            fill_cnt_q    <= '0;
        end else if (wr_en) begin
            if (!fill_active_q)
                room_q <= room_now;
            fill_active_q <= 1'b1;
            if (byte_fits)
                fill_cnt_q <= fill_cnt_q + CNT_W'(1);
            else
                long_q <= 1'b1;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt_q <= SLOT_LIM);                                   // R11
    AST_LONG_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        long_q |-> !commit);                                       // R11
    AST_BAD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (eop && !eop_good) |-> (!commit && !drop));                 // R10

endmodule

// File: rtl/oep_queue_ctrl.sv
// Packet queue bookkeeping for up to two held packets.
// Keeps the head and tail slot pointers, the per-slot lengths, the CPU
// read index and the overrun flag. Releases the head on clear-ready or
// after its last byte is popped when auto-clear is on.
// Assumes dbl_mode changes only while no packet is held.
module oep_queue_ctrl #(
    parameter int SLOT_BYTES = 64,
    parameter int CNT_W      = $clog2(SLOT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbl_mode,
    input  logic             auto_clr,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_len,
    input  logic             drop,
    input  logic             pop,
    input  logic             clr_rdy,
    input  logic             overrun_clr,
    output logic             room_now,
    output logic             tail_slot,
    output logic             head_slot,
    output logic [1:0]       held,
    output logic [CNT_W-1:0] head_len,
    output logic [CNT_W-1:0] rd_idx,
    output logic             rd_hit,
    output logic             overrun
);
    localparam int NSLOT = 2;

    logic             head_q;
    logic             tail_q;
    logic [1:0]       held_q;
    logic [CNT_W-1:0] rd_idx_q;
    logic             ovr_q;
    logic [CNT_W-1:0] len_q [NSLOT];

    logic [1:0]       cap;
    logic [CNT_W-1:0] cur_len;
    logic             any_held;
    logic             auto_rel;
    logic             release_head;

    // Capacity, head lookup and release decision.
    always_comb begin
        cap          = dbl_mode ? 2'd2 : 2'd1;
        room_now     = held_q < cap;
        any_held     = held_q != 2'd0;
        cur_len      = len_q[head_q];
        rd_hit       = pop && any_held && (rd_idx_q < cur_len);
        auto_rel     = auto_clr && rd_hit && ((rd_idx_q + CNT_W'(1)) == cur_len);
        release_head = (clr_rdy && any_held) || auto_rel;
        tail_slot    = tail_q;
        head_slot    = head_q;
        held         = held_q;
        head_len     = any_held ? cur_len : '0;
        rd_idx       = rd_idx_q;
        overrun      = ovr_q;
    end

    // Advances pointers and the held count on commit and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= 1'b0;
            tail_q <= 1'b0;
            held_q <= 2'd0;
        end else begin
            if (commit)
                tail_q <= ~tail_q;
            if (release_head)
                head_q <= ~head_q;
            held_q <= held_q + {1'b0, commit} - {1'b0, release_head};
        end
    end

    // Records the length of each committed packet in its slot.
    for (genvar s = 0; s < NSLOT; s++) begin : g_len
        always_ff @(posedge clk) begin
            if (!rst_n)
                len_q[s] <= '0;
            else if (commit && (tail_q == 1'(s)))
                len_q[s] <= commit_len;
        end
    end

    // Steps the CPU read index through the head packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_idx_q <= '0;
        else if (release_head)
            rd_idx_q <= '0;
        else if (rd_hit)
            rd_idx_q <= rd_idx_q + CNT_W'(1);
    end

    // Sticky overrun flag; a new drop takes precedence over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (drop)
            ovr_q <= 1'b1;
        else if (overrun_clr)
            ovr_q <= 1'b0;
    end

    AST_HELD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= cap);                                            // R4
    AST_DROP_KEEPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !release_head) |=> $stable(held_q));              // R9
    AST_DROP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr_q);                                           // R9
    AST_CLR_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rdy && !any_held && !commit) |=> (held_q == 2'd0));   // R7
    AST_RDIDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        any_held |-> (rd_idx_q <= cur_len));                       // R12

endmodule

// File: rtl/usb_out_ep_buffer.sv
// Receive buffer for one USB OUT endpoint.
// Joins the bus-side assembler, the packet queue and the two-slot storage,
// and encodes the CPU status code from the mode and held count.
// Assumes one-cycle eop, clr_rdy, pop and overrun_clr pulses.
module usb_out_ep_buffer #(
    parameter int SLOT_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl_mode,
    input  logic              auto_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              eop,
    input  logic              eop_good,
    output logic [1:0]        status,
    output logic [CNT_W-1:0]  head_len,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              clr_rdy,
    output logic              overrun,
    input  logic              overrun_clr
);
    import oep_pkg::*;

    logic             room_now;
    logic             mem_we;
    logic [CNT_W-1:0] fill_idx;
    logic             commit;
    logic [CNT_W-1:0] commit_len;
    logic             drop;
    logic             tail_slot;
    logic             head_slot;
    logic [1:0]       held;
    logic [CNT_W-1:0] rd_idx;
    logic             rd_hit;

    oep_fill_ctrl #(.SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .eop        (eop),
        .eop_good   (eop_good),
        .room_now   (room_now),
        .mem_we     (mem_we),
        .fill_idx   (fill_idx),
        .commit     (commit),
        .commit_len (commit_len),
        .drop       (drop)
    );

    oep_queue_ctrl #(.SLOT_BYTES(SLOT_BYTES), .CNT_W(CNT_W)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbl_mode    (dbl_mode),
        .auto_clr    (auto_clr),
        .commit      (commit),
        .commit_len  (commit_len),
        .drop        (drop),
        .pop         (pop),
        .clr_rdy     (clr_rdy),
        .overrun_clr (overrun_clr),
        .room_now    (room_now),
        .tail_slot   (tail_slot),
        .head_slot   (head_slot),
        .held        (held),
        .head_len    (head_len),
        .rd_idx      (rd_idx),
        .rd_hit      (rd_hit),
        .overrun     (overrun)
    );

    oep_slot_ram #(.SLOT_BYTES(SLOT_BYTES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .wr_slot (tail_slot),
        .wr_idx  (fill_idx),
        .wr_data (wr_byte),
        .rd_en   (pop),
        .rd_hit  (rd_hit),
        .rd_slot (head_slot),
        .rd_idx  (rd_idx),
        .rd_data (pop_data)
    );

    // Status code seen by the CPU.
    always_comb begin
        status = enc_status(dbl_mode, held);
    end

    AST_NO_CODE_01: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b01);                                          // R2
    AST_SINGLE_NO_10: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl_mode |-> (status != 2'b10));                          // R3
    AST_EMPTY_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00) |-> (head_len == '0));                   // R5
    AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && status == 2'b00) |=> (pop_data == '0));            // R12

endmodule

// File: tb/tb_usb_out_ep_buffer.sv
module tb_usb_out_ep_buffer;
    localparam int SLOT  = 8;
    localparam int CW    = $clog2(SLOT + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbl_mode = 1'b0;
    logic          auto_clr = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_byte = '0;
    logic          eop = 1'b0;
    logic          eop_good = 1'b0;
    logic [1:0]    status;
    logic [CW-1:0] head_len;
    logic          pop = 1'b0;
    logic [7:0]    pop_data;
    logic          clr_rdy = 1'b0;
    logic          overrun;
    logic          overrun_clr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    usb_out_ep_buffer #(.SLOT_BYTES(SLOT)) dut (
        .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .auto_clr(auto_clr),
        .wr_en(wr_en), .wr_byte(wr_byte), .eop(eop), .eop_good(eop_good),
        .status(status), .head_len(head_len), .pop(pop), .pop_data(pop_data),
        .clr_rdy(clr_rdy), .overrun(overrun), .overrun_clr(overrun_clr)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_pkt(input int len, input int base, input logic good);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_byte = 8'(base + i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        eop = 1'b1;
        eop_good = good;
        @(negedge clk);
        eop = 1'b0;
    endtask

    task automatic pop_one(output int val);
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        val = int'(pop_data);
    endtask

    task automatic pop_pkt(input string req, input int len, input int base);
        int v;
        for (int i = 0; i < len; i++) begin
            pop_one(v);
            chk(req, v, (base + i) & 8'hFF);
        end
    endtask

    task automatic clear_head();
        @(negedge clk);
        clr_rdy = 1'b1;
        @(negedge clk);
        clr_rdy = 1'b0;
    endtask

    task automatic clear_ovr();
        @(negedge clk);
        overrun_clr = 1'b1;
        @(negedge clk);
        overrun_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", int'(status), 0);
        chk("R1 head_len", int'(head_len), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 pop_data", int'(pop_data), 0);
    endtask

    task automatic t_empty_pop();
        int v;
        pop_one(v);
        chk("R12 empty pop data", v, 0);
        chk("R12 empty pop status", int'(status), 0);
        chk("R2 empty status 00", int'(status), 0);
    endtask

    task automatic t_single();
        int v;
        dbl_mode = 1'b0;
        send_pkt(5, 8'h10, 1'b1);
        chk("R3 single one held", int'(status), 3);
        chk("R5 head_len", int'(head_len), 5);
        pop_pkt("R6 byte order", 5, 8'h10);
        pop_one(v);
        chk("R12 pop past end", v, 0);
        chk("R12 status after over-pop", int'(status), 3);
        clear_head();
        chk("R7 released", int'(status), 0);
        chk("R5 len when empty", int'(head_len), 0);
        clear_head();
        chk("R7 clr on empty ignored", int'(status), 0);
        send_pkt(2, 8'h20, 1'b1);
        chk("R7 held after stray clr", int'(status), 3);
        pop_pkt("R7 data after stray clr", 2, 8'h20);
        clear_head();
    endtask

    task automatic t_single_ovr();
        dbl_mode = 1'b0;
        send_pkt(3, 8'h30, 1'b1);
        send_pkt(4, 8'h40, 1'b1);
        chk("R3 second pkt overrun", int'(overrun), 1);
        chk("R9 held unchanged status", int'(status), 3);
        chk("R9 held unchanged len", int'(head_len), 3);
        pop_pkt("R9 held data intact", 3, 8'h30);
        clear_ovr();
        chk("R9 flag cleared", int'(overrun), 0);
        clear_head();
        chk("R9 buffer empty", int'(status), 0);
    endtask

    task automatic t_double();
        dbl_mode = 1'b1;
        send_pkt(3, 8'h50, 1'b1);
        chk("R4 one held", int'(status), 2);
        send_pkt(6, 8'h60, 1'b1);
        chk("R4 two held", int'(status), 3);
        chk("R13 len is head", int'(head_len), 3);
        send_pkt(2, 8'h70, 1'b1);
        chk("R9 double full overrun", int'(overrun), 1);
        chk("R9 double held kept", int'(status), 3);
        clear_ovr();
        pop_pkt("R13 first pkt data", 3, 8'h50);
        clear_head();
        chk("R13 one left", int'(status), 2);
        chk("R13 len follows head", int'(head_len), 6);
        send_pkt(2, 8'h80, 1'b1);
        chk("R13 reused slot", int'(status), 3);
        pop_pkt("R13 second pkt data", 6, 8'h60);
        clear_head();
        chk("R13 len third", int'(head_len), 2);
        pop_pkt("R13 third pkt data", 2, 8'h80);
        clear_head();
        chk("R13 drained", int'(status), 0);
    endtask

    task automatic t_auto();
        dbl_mode = 1'b1;
        auto_clr = 1'b1;
        send_pkt(4, 8'h90, 1'b1);
        send_pkt(2, 8'hA0, 1'b1);
        pop_pkt("R8 auto data first", 3, 8'h90);
        chk("R8 not yet released", int'(status), 3);
        pop_pkt("R8 auto last byte", 1, 8'h93);
        chk("R8 auto released", int'(status), 2);
        chk("R8 len next", int'(head_len), 2);
        pop_pkt("R8 auto data second", 2, 8'hA0);
        chk("R8 auto drained", int'(status), 0);
        auto_clr = 1'b0;
    endtask

    task automatic t_bad_long();
        dbl_mode = 1'b1;
        send_pkt(4, 8'hB0, 1'b0);
        chk("R10 bad discarded", int'(status), 0);
        chk("R10 no overrun", int'(overrun), 0);
        send_pkt(SLOT + 1, 8'hC0, 1'b1);
        chk("R11 long discarded", int'(status), 0);
        send_pkt(SLOT, 8'hD0, 1'b1);
        chk("R11 exact fit held", int'(status), 2);
        chk("R11 exact fit len", int'(head_len), SLOT);
        pop_pkt("R11 exact fit data", SLOT, 8'hD0);
        clear_head();
        chk("R11 drained", int'(status), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_pop();
        t_single();
        t_single_ovr();
        t_double();
        t_auto();
        t_bad_long();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule